// File: doc/BRIEF.md
# Bit-Serial Addressed I/O Unit

This unit gives a processor core access to a separate I/O space of 4096 single-bit locations. The space is meant for chains of external shift registers and latches. It is not part of the memory bus. The decoder hands the unit a command together with a software base register, a field width code, a signed displacement and a data word. The unit then walks the I/O space one bit per clock. On every cycle of a command it drives a 12-bit bit address. For writes it also drives a data bit and a write strobe. For reads it samples a single input line.

Field commands move 1 to 16 bits. The first bit goes to or from the base address and each following bit uses the next address up. Single-bit commands set, clear or test one location. That location is found by adding a signed displacement to the base address. When the last bit has been handled, a one-cycle done pulse is raised. A field read delivers its result word in that same cycle, and a test delivers its flag in that same cycle.

Top module: `bitio_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy`, `done`, `sio_wstb`, `eq_flag`, `rdata` and `sio_addr` are all zero.
- R2: Op code 0 is a field read. It takes N bits from addresses A, A+1, ... A+N-1. A is `base_reg[12:1]`. The bit read from A becomes the field LSB. `done` rises exactly N cycles after the first cycle following acceptance.
- R3: A width code of 0 selects a 16-bit field. Codes 1 to 15 select that many bits.
- R4: For a field read with N of 8 or less, the field sits in `rdata[15:8]`, with its LSB at `rdata[8]`, and every other bit is zero. For N of 9 or more, the field sits in `rdata[N-1:0]` and the upper bits are zero.
- R5: Op code 1 is a field write. It presents N bits, one per cycle. Each bit is shown with its address and with `sio_wstb` high for that cycle. For N of 8 or less the source is `wdata[15:8]`, starting at `wdata[8]`. Otherwise the source is `wdata`, starting at `wdata[0]`. Exactly N strobes occur.
- R6: During field transfers the address wraps from 4095 to 0.
- R7: A single-bit command addresses `base_reg[12:1]` plus `disp`, where `disp` is 8-bit two's complement, and the sum wraps modulo 4096. Base bit 0 and base bits 15:13 are ignored.
- R8: Op code 2 writes a 1 with one strobe. Op code 3 writes a 0 with one strobe.
- R9: Op code 4 samples the addressed bit into `eq_flag`. It leaves `rdata` unchanged and issues no strobe.
- R10: A command offered while `busy` is high is ignored.
- R11: `done` is a one-cycle pulse and `busy` is low while it is high. A command offered in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 3 | 0 field read, 1 field write, 2 set, 3 clear, 4 test |
| base_reg | input | 16 | Software base register; bits 12:1 give the bit address |
| width_code | input | 4 | Field width, 0 means 16 |
| disp | input | 8 | Signed displacement for single-bit commands |
| wdata | input | 16 | Source word for field writes |
| sio_din | input | 1 | Serial input bit for the address currently driven |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Result of the last field read |
| eq_flag | output | 1 | Bit sampled by the last test |
| sio_addr | output | 12 | Current bit address |
| sio_dout | output | 1 | Output data bit |
| sio_wstb | output | 1 | Write strobe for the current bit |

## Verification
Two events can land in the same cycle: the done pulse of one command and the acceptance of the next one. The bench provokes this by offering a test command exactly in the done cycle of a field read. It then checks that the read result is still correct and that the test completes one cycle later with the right flag. A second collision is a new command arriving in the middle of a long field write. That case is judged at the I/O model: the stray target bit must stay untouched, and the strobe count must equal the field length.

// File: rtl/bitio_pkg.sv
package bitio_pkg;
  typedef enum logic [2:0] {
    OP_FIELD_IN  = 3'd0,
    OP_FIELD_OUT = 3'd1,
    OP_BIT_SET   = 3'd2,
    OP_BIT_CLR   = 3'd3,
    OP_BIT_TEST  = 3'd4
  } bitio_op_e;
endpackage

// File: rtl/bitio_addr_gen.sv
module bitio_addr_gen
  import bitio_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int DISP_W = 8,
  localparam int WC_W  = $clog2(DATA_W),
  localparam int CNT_W = WC_W + 1
) (
  input  bitio_op_e          op,
  input  logic [DATA_W-1:0]  base_reg,
  input  logic [WC_W-1:0]    width_code,
  input  logic [DISP_W-1:0]  disp,
  output logic [ADDR_W-1:0]  start_addr,
  output logic [CNT_W-1:0]   bit_count,
  output logic               is_input
);
  logic [ADDR_W-1:0] base_addr;
  logic [ADDR_W-1:0] disp_ext;
  logic              is_field;
  logic              unused_base_bits;

  assign base_addr        = base_reg[ADDR_W:1];
  assign unused_base_bits = ^{base_reg[0], base_reg[DATA_W-1:ADDR_W+1]};
  assign disp_ext         = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign is_field         = (op == OP_FIELD_IN) || (op == OP_FIELD_OUT);

  always_comb begin
    if (is_field) begin
      start_addr = base_addr;
      bit_count  = (width_code == '0) ? CNT_W'(DATA_W) : {1'b0, width_code};
    end else begin
      start_addr = base_addr + disp_ext;
      bit_count  = CNT_W'(1);
    end
    is_input = (op == OP_FIELD_IN) || (op == OP_BIT_TEST);
  end
endmodule

// File: rtl/bitio_ctrl.sv
module bitio_ctrl #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_input,
  input  logic [CNT_W-1:0]  bit_count,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              last,
  output logic              done,
  output logic [ADDR_W-1:0] sio_addr,
  output logic              sio_wstb
);
  logic [CNT_W-1:0] remain_q;

  assign last = busy && (remain_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      remain_q <= '0;
      sio_addr <= '0;
      sio_wstb <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          remain_q <= bit_count;
          sio_addr <= start_addr;
          sio_wstb <= !is_input;
        end
      end else if (last) begin
        busy     <= 1'b0;
        sio_wstb <= 1'b0;
        done     <= 1'b1;
      end else begin
        remain_q <= remain_q - CNT_W'(1);
        sio_addr <= sio_addr + ADDR_W'(1);
      end
    end
  end
endmodule

// File: rtl/bitio_shifter.sv
module bitio_shifter
  import bitio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5,
  localparam int HALF  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  bitio_op_e         op,
  input  logic [CNT_W-1:0]  bit_count,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              last,
  input  logic              sio_din,
  output logic              sio_dout,
  output logic [DATA_W-1:0] rdata,
  output logic              eq_flag
);
  bitio_op_e         op_q;
  logic [CNT_W-1:0]  len_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] src_word;
  logic [DATA_W-1:0] gathered;
  logic [DATA_W-1:0] aligned;
  logic [DATA_W-1:0] placed;
  logic [CNT_W-1:0]  rshift;

  always_comb begin
    case (op)
      OP_BIT_SET: src_word = DATA_W'(1);
      OP_BIT_CLR: src_word = '0;
      default:
        src_word = (bit_count <= CNT_W'(HALF))
                 ? {{HALF{1'b0}}, wdata[DATA_W-1:HALF]} : wdata;
    endcase
  end

  always_comb begin
    gathered = {sio_din, rx_q[DATA_W-1:1]};
    rshift   = CNT_W'(DATA_W) - len_q;
    aligned  = gathered >> rshift;
    placed   = (len_q <= CNT_W'(HALF)) ? (aligned << HALF) : aligned;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= OP_FIELD_IN;
      len_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      sio_dout <= 1'b0;
      rdata    <= '0;
      eq_flag  <= 1'b0;
    end else if (start) begin
      op_q     <= op;
      len_q    <= bit_count;
      sio_dout <= src_word[0];
      tx_q     <= src_word >> 1;
      rx_q     <= '0;
    end else if (busy) begin
      if (last) begin
        if (op_q == OP_BIT_TEST) eq_flag <= sio_din;
        if (op_q == OP_FIELD_IN) rdata   <= placed;
      end else begin
        sio_dout <= tx_q[0];
        tx_q     <= tx_q >> 1;
        rx_q     <= gathered;
      end
    end
  end
endmodule

// File: rtl/bitio_unit.sv
module bitio_unit
  import bitio_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int DISP_W = 8,
  localparam int WC_W  = $clog2(DATA_W),
  localparam int CNT_W = WC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] base_reg,
  input  logic [WC_W-1:0]   width_code,
  input  logic [DISP_W-1:0] disp,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sio_din,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              eq_flag,
  output logic [ADDR_W-1:0] sio_addr,
  output logic              sio_dout,
  output logic              sio_wstb
);
  bitio_op_e         op;
  logic              start;
  logic              last;
  logic              is_input;
  logic [CNT_W-1:0]  bit_count;
  logic [ADDR_W-1:0] start_addr;

  assign op    = bitio_op_e'(cmd_op);
  assign start = cmd_valid && !busy;

  bitio_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DISP_W(DISP_W)) u_addr (
    .op(op), .base_reg(base_reg), .width_code(width_code), .disp(disp),
    .start_addr(start_addr), .bit_count(bit_count), .is_input(is_input)
  );

  bitio_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .is_input(is_input),
    .bit_count(bit_count), .start_addr(start_addr), .busy(busy),
    .last(last), .done(done), .sio_addr(sio_addr), .sio_wstb(sio_wstb)
  );

  bitio_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .op(op), .bit_count(bit_count),
    .wdata(wdata), .busy(busy), .last(last), .sio_din(sio_din),
    .sio_dout(sio_dout), .rdata(rdata), .eq_flag(eq_flag)
  );
endmodule

// File: rtl/bitio_checker.sv
module bitio_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              sio_wstb,
  input logic [ADDR_W-1:0] sio_addr,
  input logic [DATA_W-1:0] rdata
);
  p_strobe_in_xfer_r5: assert property (@(posedge clk) disable iff (rst)
    sio_wstb |-> busy);

  p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (sio_addr == ADDR_W'($past(sio_addr) + 1'b1)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_result_at_done_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata) |-> done);
endmodule

bind bitio_unit bitio_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .sio_wstb(sio_wstb),
  .sio_addr(sio_addr), .rdata(rdata)
);

// File: tb/test_bitio_unit.sv
module test_bitio_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] base_reg = 16'd0;
  logic [3:0]  width_code = 4'd0;
  logic [7:0]  disp = 8'd0;
  logic [15:0] wdata = 16'd0;
  logic        sio_din;
  logic        busy, done, eq_flag, sio_dout, sio_wstb;
  logic [15:0] rdata;
  logic [11:0] sio_addr;

  logic io_mem [0:4095];
  int   strobes = 0;
  int   tests = 0;
  int   fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sio_din = io_mem[sio_addr];

  always @(posedge clk) begin
    if (!rst && sio_wstb) begin
      io_mem[sio_addr] <= sio_dout;
      strobes <= strobes + 1;
    end
  end

  bitio_unit i_bitio_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .base_reg(base_reg), .width_code(width_code), .disp(disp),
    .wdata(wdata), .sio_din(sio_din), .busy(busy), .done(done),
    .rdata(rdata), .eq_flag(eq_flag), .sio_addr(sio_addr),
    .sio_dout(sio_dout), .sio_wstb(sio_wstb)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_base(input int a, input bit junk);
    return junk ? {3'b101, 12'(a), 1'b1} : {3'b000, 12'(a), 1'b0};
  endfunction

  function automatic logic [15:0] exp_read(input int a, input int n);
    logic [15:0] f = '0;
    for (int i = 0; i < n; i++) f[i] = io_mem[(a + i) % 4096];
    return (n <= 8) ? (f << 8) : f;
  endfunction

  // drive at a negedge, return at the negedge where done is seen
  task automatic run(input logic [2:0] op, input logic [15:0] b,
                     input logic [3:0] wc, input logic [7:0] d,
                     input logic [15:0] wd, output int lat);
    cmd_op = op; base_reg = b; width_code = wc; disp = d; wdata = wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0;
    while (!done && lat < 64) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset;
    check(busy == 0 && done == 0 && sio_wstb == 0, "R1", "control idle",
          {busy, done, sio_wstb}, 0);
    check(rdata == 0 && eq_flag == 0 && sio_addr == 0, "R1", "data zero",
          {rdata, eq_flag, sio_addr}, 0);
  endtask

  task automatic t_read(input int a, input logic [3:0] wc, input int n,
                        input string req);
    int lat;
    logic [15:0] exp = exp_read(a, n);
    strobes = 0;
    run(3'd0, mk_base(a, 0), wc, 8'd0, 16'h0, lat);
    check(rdata == exp, req, "field read value", rdata, exp);
    check(lat == n, "R2", "read latency", lat, n);
    check(strobes == 0, "R2", "no strobe on read", strobes, 0);
    @(negedge clk);
    check(!done, "R11", "done single cycle", done, 0);
  endtask

  task automatic t_write8;
    int lat;
    logic before_lo = io_mem[499];
    logic before_hi = io_mem[508];
    strobes = 0;
    run(3'd1, mk_base(500, 0), 4'd8, 8'd0, 16'hA53C, lat);
    @(negedge clk);
    for (int i = 0; i < 8; i++)
      check(io_mem[500 + i] == wdata[8 + i], "R5", "byte write bit",
            io_mem[500 + i], wdata[8 + i]);
    check(strobes == 8, "R5", "strobe count", strobes, 8);
    check(io_mem[499] == before_lo && io_mem[508] == before_hi, "R5",
          "neighbours untouched", {io_mem[499], io_mem[508]},
          {before_lo, before_hi});
  endtask

  task automatic t_wrap;
    int lat;
    strobes = 0;
    run(3'd1, mk_base(4090, 0), 4'd0, 8'd0, 16'hBEEF, lat);
    @(negedge clk);
    for (int i = 0; i < 16; i++)
      check(io_mem[(4090 + i) % 4096] == wdata[i], "R6", "wrapped write bit",
            io_mem[(4090 + i) % 4096], wdata[i]);
    check(strobes == 16, "R3", "16-bit strobes", strobes, 16);
    run(3'd0, mk_base(4090, 0), 4'd0, 8'd0, 16'h0, lat);
    check(rdata == 16'hBEEF, "R6", "wrapped read back", rdata, 16'hBEEF);
    @(negedge clk);
  endtask

  task automatic t_bits;
    int lat;
    io_mem[7] = 1'b0;
    strobes = 0;
    run(3'd2, mk_base(10, 1), 4'd5, 8'hFD, 16'h0, lat);
    @(negedge clk);
    check(io_mem[7] == 1'b1, "R7", "set at negative displacement", io_mem[7], 1);
    check(strobes == 1, "R8", "set one strobe", strobes, 1);
    io_mem[31] = 1'b1;
    strobes = 0;
    run(3'd3, mk_base(4000, 1), 4'd0, 8'd127, 16'hFFFF, lat);
    @(negedge clk);
    check(io_mem[31] == 1'b0, "R8", "clear wrapped address", io_mem[31], 0);
    check(strobes == 1 && lat == 1, "R7", "single strobe, one cycle",
          {strobes[15:0], lat[15:0]}, {16'd1, 16'd1});
  endtask

  task automatic t_test;
    int lat;
    logic [15:0] keep = rdata;
    io_mem[55] = 1'b1;
    strobes = 0;
    run(3'd4, mk_base(50, 0), 4'd0, 8'd5, 16'h0, lat);
    check(eq_flag == 1'b1, "R9", "test reads one", eq_flag, 1);
    @(negedge clk);
    io_mem[55] = 1'b0;
    run(3'd4, mk_base(50, 0), 4'd0, 8'd5, 16'h0, lat);
    check(eq_flag == 1'b0, "R9", "test reads zero", eq_flag, 0);
    check(rdata == keep && strobes == 0, "R9", "rdata kept, no strobe",
          rdata, keep);
    @(negedge clk);
  endtask

  task automatic t_busy;
    int lat;
    io_mem[3000] = 1'b0;
    strobes = 0;
    cmd_op = 3'd1; base_reg = mk_base(1000, 0); width_code = 4'd0;
    wdata = 16'hFFFF; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    cmd_op = 3'd2; base_reg = mk_base(3000, 0); disp = 8'd0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0;
    while (!done && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    repeat (2) @(negedge clk);
    check(io_mem[3000] == 1'b0, "R10", "command during busy ignored",
          io_mem[3000], 0);
    check(strobes == 16, "R10", "only field strobes", strobes, 16);
  endtask

  task automatic t_back2back;
    int lat;
    logic [15:0] exp;
    io_mem[710] = 1'b1;
    exp = exp_read(700, 4);
    run(3'd0, mk_base(700, 0), 4'd4, 8'd0, 16'h0, lat);
    // done of the read is high now: offer the test in this same cycle
    cmd_op = 3'd4; base_reg = mk_base(700, 0); disp = 8'd10; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy && !done, "R11", "accepted in done cycle", {busy, done}, 2'b10);
    check(rdata == exp, "R4", "read result survives", rdata, exp);
    @(negedge clk);
    check(done && eq_flag == 1'b1, "R11", "test completes next cycle",
          {done, eq_flag}, 2'b11);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) io_mem[i] = ((i * 37 + 5) % 7) < 3;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(100, 4'd5, 5, "R4");
    t_read(2000, 4'd12, 12, "R4");
    t_read(300, 4'd0, 16, "R3");
    t_read(3, 4'd1, 1, "R2");
    t_write8();
    t_wrap();
    t_bits();
    t_test();
    t_busy();
    t_back2back();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule